// File: doc/BRIEF.md
# Ciphertext-Autokey Bit-Serial Encryptor

This block encrypts or decrypts a stream one bit per clock under a 138-bit key held in an internal register. Each accepted input bit is first run through a differential stage. It is then XORed with a key-stream bit and returned one cycle later as a registered output. The key stream comes from the cipher's own history. Every ciphertext bit is pushed into a 21-bit history register. The seven newest history bits address one of the low 128 key bits, and that bit, XORed with the oldest history bit, enters a 10-bit modified history register. A fixed ladder of ten XOR stages folds the modified register into one key-stream bit. Eight of those stages are switched by the top eight key bits, one stage is always active, and the last stage passes its input through unchanged.

The key is written through a parallel port while no bit is being accepted. A one-cycle clear pulse returns the cipher state to zero and keeps the key. A mode input selects decryption. In that mode the received ciphertext drives the same key-stream generator, so a stream encrypted from a cleared state and decrypted from a cleared state under the same key comes back unchanged.

Top module: `cak_encryptor`

## Requirements
- R1: While reset is high and on the cycle after it, `out_valid` and `out_bit` are 0. The key and all cipher state are zero.
- R2: When `clr` is low, `out_valid` equals the `in_valid` of the previous cycle. `out_bit` changes only on the cycle after an accepted bit.
- R3: For each accepted bit, the history register's seven newest bits form an address with the newest bit as the LSB. The address selects one key bit among k0..k127.
- R4: The selected key bit XORed with the 21st newest ciphertext bit is shifted into the modified register (depth 10, newest at position 0).
- R5: The key-stream bit includes modified bit i (i = 0..7) only when key bit k(130+i) is 1.
- R6: The key-stream bit always includes modified bit 8, whatever the key holds.
- R7: Modified bit 9 and key bits k128 and k129 have no effect on any output.
- R8: In encrypt mode (`decrypt` = 0), d = p XOR d_prev and the ciphertext is d XOR key-stream, where d_prev is the previous accepted d (0 after reset or clear).
- R9: In decrypt mode, the input ciphertext enters the history register and d = c XOR key-stream. The output is d XOR d_prev, so decrypting the ciphertext of a stream from the same start state returns the original bits.
- R10: A key write takes effect only when `key_load` is high and `in_valid` is low. A write with `in_valid` high is ignored.
- R11: A `clr` pulse zeroes both history registers, the differential state and the outputs, and leaves the key unchanged.
- R12: Cycles with `in_valid` low leave all cipher state unchanged, so idle gaps do not alter the ciphertext sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Cipher state clear pulse (key kept) |
| key_load | input | 1 | Key write strobe, honoured when `in_valid` is low |
| key_in | input | 138 | Key value, bit i is k(i) |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Plaintext (encrypt) or ciphertext (decrypt) bit |
| out_valid | output | 1 | Output bit strobe, one cycle after `in_valid` |
| out_bit | output | 1 | Ciphertext (encrypt) or recovered plaintext (decrypt) |

## Verification
The bench uses the default geometry: a 138-bit key, a 7-bit address over 128 key bits, a 21-deep history tap, a 10-deep modified register and eight gated stages. Runs of 64 bits and longer push the history well past the 21-bit tap, so the feedback of past ciphertext into key-bit selection is active for most of each run. The keys include gating bytes of all zeros, all ones and mixed values, which isolate the always-on stage and the switched stages. Two keys that differ only in k128 and k129 show that those bits are dead.

// File: rtl/cak_pkg.sv
package cak_pkg;

    localparam int KEY_BITS     = 138;
    localparam int ADDR_BITS    = 7;
    localparam int CT_TAP       = 21;
    localparam int MOD_DEPTH    = 10;
    localparam int GATED_STAGES = 8;

    typedef enum logic [1:0] {
        STG_GATED  = 2'd0,
        STG_ALWAYS = 2'd1,
        STG_PASS   = 2'd2
    } stage_kind_e;

    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } cipher_mode_e;

    typedef struct packed {
        logic valid;
        logic bit_val;
    } bit_beat_t;

    // Kind of XOR stage at position idx: gated ones first, then a single
    // always-on stage, then pass-through stages.
    function automatic stage_kind_e stage_kind(input int idx, input int gated);
        if (idx < gated)       return STG_GATED;
        else if (idx == gated) return STG_ALWAYS;
        else                   return STG_PASS;
    endfunction

endpackage

// File: rtl/cak_keystream.sv
module cak_keystream #(
    parameter int ADDR_W = cak_pkg::ADDR_BITS,
    parameter int TAP    = cak_pkg::CT_TAP,
    parameter int MOD_D  = cak_pkg::MOD_DEPTH,
    localparam int POOL  = 2 ** ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             ct_bit,
    input  logic [POOL-1:0]  key_pool,
    output logic [TAP-1:0]   ct_hist,
    output logic [MOD_D-1:0] mod_hist
);

    logic [ADDR_W-1:0] addr;
    logic              sel_bit;
    logic              mod_new;

    assign addr    = ct_hist[ADDR_W-1:0];
    assign sel_bit = key_pool[addr];
    assign mod_new = sel_bit ^ ct_hist[TAP-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ct_hist  <= '0;
            mod_hist <= '0;
        end else if (adv) begin
            ct_hist  <= {ct_hist[TAP-2:0], ct_bit};
            mod_hist <= {mod_hist[MOD_D-2:0], mod_new};
        end
    end

endmodule

// File: rtl/cak_mix_chain.sv
module cak_mix_chain #(
    parameter int MOD_D = cak_pkg::MOD_DEPTH,
    parameter int GATED = cak_pkg::GATED_STAGES
) (
    input  logic [MOD_D-1:0] mod_hist,
    input  logic [GATED-1:0] gate_key,
    output logic             ks_bit
);
    import cak_pkg::*;

    logic [MOD_D:0] part;
    assign part[0] = 1'b0;

    for (genvar i = 0; i < MOD_D; i++) begin : g_stage
        localparam stage_kind_e KIND = stage_kind(i, GATED);
        if (KIND == STG_GATED) begin : g_gated
            assign part[i+1] = part[i] ^ (mod_hist[i] & gate_key[i]);
        end else if (KIND == STG_ALWAYS) begin : g_always
            assign part[i+1] = part[i] ^ mod_hist[i];
        end else begin : g_pass
            logic unused_tap;
            assign unused_tap = mod_hist[i];
            assign part[i+1]  = part[i];
        end
    end

    assign ks_bit = part[MOD_D];

endmodule

// File: rtl/cak_diff_stage.sv
module cak_diff_stage (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    input  logic dec,
    input  logic in_bit,
    input  logic ks_bit,
    output logic res_bit,
    output logic ct_bit
);

    logic d_prev;
    logic d_now;

    // d is the differentially coded plaintext on both directions
    assign d_now   = dec ? (in_bit ^ ks_bit) : (in_bit ^ d_prev);
    assign res_bit = dec ? (d_now ^ d_prev)  : (d_now ^ ks_bit);
    assign ct_bit  = dec ? in_bit : res_bit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            d_prev <= 1'b0;
        end else if (adv) begin
            d_prev <= d_now;
        end
    end

endmodule

// File: rtl/cak_encryptor.sv
module cak_encryptor #(
    parameter int KEY_W  = cak_pkg::KEY_BITS,
    parameter int ADDR_W = cak_pkg::ADDR_BITS,
    parameter int TAP    = cak_pkg::CT_TAP,
    parameter int MOD_D  = cak_pkg::MOD_DEPTH,
    parameter int GATED  = cak_pkg::GATED_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             key_load,
    input  logic [KEY_W-1:0] key_in,
    input  logic             decrypt,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             out_valid,
    output logic             out_bit
);
    import cak_pkg::*;

    localparam int POOL      = 2 ** ADDR_W;
    localparam int DEAD_BITS = KEY_W - POOL - GATED;

    logic [KEY_W-1:0] key_q;
    logic [TAP-1:0]   ct_hist;
    logic [MOD_D-1:0] mod_hist;
    logic             ks_bit;
    logic             res_bit;
    logic             ct_bit;
    logic             adv;
    cipher_mode_e     mode;
    bit_beat_t        out_q;

    assign adv  = in_valid && !clr;
    assign mode = cipher_mode_e'(decrypt);

    // key bits between the address pool and the gate byte drive nothing
    logic unused_dead_keys;
    assign unused_dead_keys = ^key_q[POOL +: DEAD_BITS];

    cak_keystream #(
        .ADDR_W (ADDR_W),
        .TAP    (TAP),
        .MOD_D  (MOD_D)
    ) u_ks (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .adv      (adv),
        .ct_bit   (ct_bit),
        .key_pool (key_q[POOL-1:0]),
        .ct_hist  (ct_hist),
        .mod_hist (mod_hist)
    );

    cak_mix_chain #(
        .MOD_D (MOD_D),
        .GATED (GATED)
    ) u_mix (
        .mod_hist (mod_hist),
        .gate_key (key_q[KEY_W-1 -: GATED]),
        .ks_bit   (ks_bit)
    );

    cak_diff_stage u_diff (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .adv     (adv),
        .dec     (mode == MODE_DEC),
        .in_bit  (in_bit),
        .ks_bit  (ks_bit),
        .res_bit (res_bit),
        .ct_bit  (ct_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            out_q <= '0;
        end else begin
            if (key_load && !in_valid) begin
                key_q <= key_in;
            end
            if (clr) begin
                out_q <= '0;
            end else begin
                out_q.valid <= in_valid;
                if (in_valid) begin
                    out_q.bit_val <= res_bit;
                end
            end
        end
    end

    assign out_valid = out_q.valid;
    assign out_bit   = out_q.bit_val;

endmodule

// File: rtl/cak_encryptor_chk.sv
module cak_encryptor_chk #(
    parameter int KEY_W  = 138,
    parameter int ADDR_W = 7,
    parameter int TAP    = 21,
    parameter int MOD_D  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_bit,
    input logic [KEY_W-1:0] key_q,
    input logic [TAP-1:0]   ct_hist,
    input logic [MOD_D-1:0] mod_hist
);
    localparam int POOL = 2 ** ADDR_W;

    logic [POOL-1:0] pool;
    logic            expect_mod;
    assign pool       = key_q[POOL-1:0];
    assign expect_mod = pool[ct_hist[ADDR_W-1:0]] ^ ct_hist[TAP-1];

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_bit && ct_hist == '0 && mod_hist == '0));

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> (out_valid == $past(in_valid)));

    // R3 and R4
    a_r4_mod_entry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr) |=> (mod_hist[0] == $past(expect_mod)));

    // R10
    a_r10_key_frozen: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $stable(key_q));

    // R11
    a_r11_clear_state: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ct_hist == '0 && mod_hist == '0 && !out_valid));

    // R12
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> ($stable(ct_hist) && $stable(mod_hist)));

endmodule

bind cak_encryptor cak_encryptor_chk #(
    .KEY_W  (KEY_W),
    .ADDR_W (ADDR_W),
    .TAP    (TAP),
    .MOD_D  (MOD_D)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .key_q     (key_q),
    .ct_hist   (ct_hist),
    .mod_hist  (mod_hist)
);

// File: tb/cak_encryptor_tb.sv
`timescale 1ns/1ps
module cak_encryptor_tb;
    localparam int KW = 138;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          key_load = 1'b0;
    logic [KW-1:0] key_in = '0;
    logic          decrypt = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          out_valid;
    logic          out_bit;

    always #2 clk = ~clk;

    cak_encryptor u_dut (
        .clk(clk), .rst(rst), .clr(clr), .key_load(key_load), .key_in(key_in),
        .decrypt(decrypt), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    logic mon_en = 1'b0;
    logic drv_v = 1'b0;
    logic exp_q[$];
    logic obs_log[$];

    // reference state built from the requirements
    logic [20:0]   m_ct = '0;
    logic [9:0]    m_mod = '0;
    logic          m_d = 1'b0;
    logic [KW-1:0] m_key = '0;
    logic [31:0]   rng = 32'h1badf00d;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[0];
    endfunction

    // R3 R4 R5 R6 R7 R8 R9 reference step
    function automatic logic model_step(input logic b, input logic dec);
        logic sel, ks, d, c, res;
        sel = m_key[int'(m_ct[6:0])];
        ks = m_mod[8];
        for (int i = 0; i < 8; i++) ks ^= m_mod[i] & m_key[130 + i];
        if (!dec) begin
            d = b ^ m_d; c = d ^ ks; res = c;
        end else begin
            d = b ^ ks; res = d ^ m_d; c = b;
        end
        m_mod = {m_mod[8:0], sel ^ m_ct[20]};
        m_ct  = {m_ct[19:0], c};
        m_d   = d;
        return res;
    endfunction

    task automatic drive(input logic v, input logic b);
        @(negedge clk);
        in_valid = v; in_bit = b; drv_v = v;
        if (v) exp_q.push_back(model_step(b, decrypt));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
    endtask

    task automatic load_key(input logic [KW-1:0] k);
        @(negedge clk);
        in_valid = 1'b0; drv_v = 1'b0; key_load = 1'b1; key_in = k;
        @(negedge clk);
        key_load = 1'b0;
        m_key = k;
    endtask

    task automatic clear_state();
        @(negedge clk);
        in_valid = 1'b0; drv_v = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_ct = '0; m_mod = '0; m_d = 1'b0;
    endtask

    task automatic run_bits(input logic src[$], input logic gaps);
        obs_log.delete();
        foreach (src[i]) begin
            drive(1'b1, src[i]);
            if (gaps && next_rand()) drive(1'b0, next_rand());
        end
        idle(3);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            check(out_valid === drv_v, "R2 out_valid", int'(out_valid), int'(drv_v));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected output", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(out_bit === e, "R3/R4/R5/R6/R8 stream bit", int'(out_bit), int'(e));
                end
                obs_log.push_back(out_bit);
            end
        end
    end

    task automatic compare_logs(input logic a[$], input logic b[$], input string req);
        check(a.size() == b.size(), req, a.size(), b.size());
        for (int i = 0; i < a.size() && i < b.size(); i++)
            if (a[i] !== b[i]) begin
                check(1'b0, req, int'(a[i]), int'(b[i]));
                break;
            end
        if (a.size() == b.size()) check(a == b, req, 1, 1);
    endtask

    logic pt[$];
    logic log_fresh[$];
    logic log_tmp[$];
    logic ct_save[$];
    logic [KW-1:0] k1 = {10'b1011010011, 128'h3c6ef372fe94f82ba54ff53a5f1d36f1};
    logic [KW-1:0] k_bad = {10'b0101010101, 128'h0123456789abcdef0fedcba987654321};
    logic [KW-1:0] k_off = {8'h00, 2'b00, 128'h9e3779b97f4a7c15f39cc0605cedc834};
    logic [KW-1:0] k_on = {8'hff, 2'b00, 128'hb5ad4eceda1ce2a9c3a8d2f4e1b0c967};
    logic [KW-1:0] k_a = {8'h5a, 2'b00, 128'hd1b54a32d192ed03aef17ac0c6f2b1e3};
    logic [KW-1:0] k_b = {8'h5a, 2'b11, 128'hd1b54a32d192ed03aef17ac0c6f2b1e3};

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_bit === 1'b0, "R1 out_bit in reset", int'(out_bit), 0);
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_bit === 1'b0, "R1 after reset", int'(out_bit), 0);

        for (int i = 0; i < 96; i++) pt.push_back(next_rand());

        // R8 encrypt from fresh state
        load_key(k1);
        run_bits(pt, 1'b0);
        log_fresh = obs_log;
        ct_save = obs_log;

        // R10 key write during a valid bit is ignored
        for (int i = 0; i < 150; i++) begin
            if (i == 40) begin
                @(negedge clk);
                in_valid = 1'b1; in_bit = 1'b1; drv_v = 1'b1;
                key_load = 1'b1; key_in = k_bad;
                exp_q.push_back(model_step(1'b1, 1'b0));
                @(negedge clk);
                key_load = 1'b0; in_valid = 1'b0; drv_v = 1'b0;
            end else begin
                drive(1'b1, next_rand());
                if (next_rand()) drive(1'b0, 1'b0);
            end
        end
        idle(3);

        // R11 clear keeps the key and resets state
        clear_state();
        run_bits(pt, 1'b0);
        compare_logs(obs_log, log_fresh, "R11 restart after clear");

        // R12 idle gaps do not change the sequence
        clear_state();
        run_bits(pt, 1'b1);
        compare_logs(obs_log, log_fresh, "R12 gaps keep sequence");

        // R9 decrypt round trip
        clear_state();
        decrypt = 1'b1;
        run_bits(ct_save, 1'b1);
        compare_logs(obs_log, pt, "R9 decrypt returns plaintext");
        decrypt = 1'b0;

        // R5 all gates off: only the always-on stage (R6) contributes
        load_key(k_off);
        clear_state();
        run_bits(pt, 1'b0);
        load_key(k_on);
        clear_state();
        run_bits(pt, 1'b1);

        // R7 k128 and k129 are dead
        load_key(k_a);
        clear_state();
        run_bits(pt, 1'b0);
        log_tmp = obs_log;
        load_key(k_b);
        clear_state();
        run_bits(pt, 1'b0);
        compare_logs(obs_log, log_tmp, "R7 k128/k129 no effect");

        check(exp_q.size() == 0, "R2 all expected outputs seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule